// File: doc/BRIEF.md
# I2C Frame Position Guard

This block sits beside an I2C controller and watches the two bus lines. It follows the frame bit by bit: idle, inside a byte (address or data), on the acknowledge clock, or at the boundary between two bytes. A START or STOP condition is allowed only while the bus is idle or at a byte boundary. If one turns up anywhere else, the block treats it as a bus error. It raises the serial interrupt flag, reports status code 0x00 and freezes until software runs the recovery handshake.

Recovery has two steps. Software first sets the stop-request bit and then clears the interrupt flag. The block then returns to a defined not-addressed slave state and clears the stop-request bit by itself. It does not drive a STOP condition onto the bus. The master and slave transfer engine is outside this block. Its open-drain pull requests pass through the block, which forces them to release while an error is pending. Software control consists of two single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `i2c_frame_guard`

## Requirements
- R1: When `si` is 0, `status` reads 0xF8. This includes the state after reset, where `si`=0, `sto`=0 and `unaddressed`=1.
- R2: While `si` is 1 because of a bus error, `status` reads 0x00.
- R3: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) is a bus error when it occurs inside an address byte, inside a data byte or during the acknowledge clock. The bus-error state is visible within four clocks of the line change.
- R4: A bus error sets `si` to 1.
- R5: A START or STOP is legal while idle. It is also legal at a byte boundary: after the falling edge of the acknowledge clock, up to the end of the high phase of the next SCL pulse. A legal condition leaves `si` at 0. A legal START clears `unaddressed`, and a legal STOP sets it.
- R6: With `si`=1, a `sto_set` strobe sets `sto` to 1. A following `si_clr` strobe clears both `si` and `sto` on the next clock, and `unaddressed` becomes 1. No STOP is driven during recovery.
- R7: `sda_pull` and `scl_pull` copy `xfer_sda_low` and `xfer_scl_low` while `si` is 0. Both are 0 while `si` is 1.
- R8: While `si` is 1, bus conditions are ignored and `si` stays at 1. An `si_clr` strobe with `sto` at 0 is also ignored.
- R9: A `sto_set` strobe while `si` is 0 is ignored, and `sto` stays at 0.
- R10: A legal START restarts the bit count of the new address byte. After a repeated START at a byte boundary, eight bits plus an acknowledge bring the frame back to a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| xfer_sda_low | input | 1 | Transfer engine asks to pull SDA low |
| xfer_scl_low | input | 1 | Transfer engine asks to pull SCL low |
| sto_set | input | 1 | Software strobe that sets the stop-request bit |
| si_clr | input | 1 | Software strobe that clears the interrupt flag |
| sda_pull | output | 1 | Open-drain SDA pull-low enable (0 = released) |
| scl_pull | output | 1 | Open-drain SCL pull-low enable (0 = released) |
| si | output | 1 | Serial interrupt flag |
| sto | output | 1 | Stop-request bit |
| status | output | 8 | Status code: 0xF8 with no information, 0x00 after a bus error |
| unaddressed | output | 1 | 1 while in the not-addressed slave state |

## Verification
The embedded assertions check four properties on every cycle:
- an illegal condition raises `si` on the next clock;
- `si` holds through everything except a complete handshake;
- `sto` can be 1 only while `si` is 1;
- the handshake clears both bits and restores the not-addressed state.

A further assertion checks that a legal START restarts the bit counter. Other behaviours only show up as whole bus scenarios, which the bench drives through the synchronizers: where in the frame a condition counts as illegal, a repeated START at a byte boundary, a STOP on the acknowledge clock, the status codes, and the release of the pull enables.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam logic [7:0] ST_NO_INFO = 8'hF8;
  localparam logic [7:0] ST_BUS_ERR = 8'h00;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BYTE = 2'd1,
    PH_ACK  = 2'd2,
    PH_GAP  = 2'd3
  } phase_t;
endpackage

// File: rtl/ifg_sync.sv
module ifg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ifg_cond_detect.sv
module ifg_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda,
  input  logic scl,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  assign start    = scl & scl_q & sda_q & ~sda;
  assign stop     = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/ifg_frame_track.sv
module ifg_frame_track
  import ifg_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic clear,
  input  logic start,
  input  logic stop,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic illegal,
  output logic legal_start,
  output logic legal_stop
);
  localparam int CW = $clog2(BYTE_BITS + 1);

  phase_t        phase;
  logic [CW-1:0] bit_cnt;
  logic          first_hi;
  logic          legal_pos;

  assign legal_pos   = (phase == PH_IDLE) || (phase == PH_GAP) || first_hi;
  assign illegal     = (start | stop) & ~legal_pos & ~freeze;
  assign legal_start = start & legal_pos & ~freeze;
  assign legal_stop  = stop & legal_pos & ~freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      first_hi <= 1'b0;
    end else if (clear) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      first_hi <= 1'b0;
    end else if (!freeze) begin
      if (legal_start) begin
        phase    <= PH_BYTE;
        bit_cnt  <= '0;
        first_hi <= 1'b0;
      end else if (legal_stop) begin
        phase    <= PH_IDLE;
        bit_cnt  <= '0;
        first_hi <= 1'b0;
      end else if (!(start | stop)) begin
        if (scl_rise) begin
          case (phase)
            PH_BYTE: begin
              if (bit_cnt == CW'(BYTE_BITS)) begin
                phase   <= PH_ACK;
                bit_cnt <= '0;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
            PH_GAP: begin
              phase    <= PH_BYTE;
              bit_cnt  <= CW'(1);
              first_hi <= 1'b1;
            end
            default: ;
          endcase
        end
        if (scl_fall) begin
          first_hi <= 1'b0;
          if (phase == PH_ACK) phase <= PH_GAP;
        end
      end
    end
  end

  // R10: a legal START opens a fresh byte with the count at zero
  assert_start_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_start && !clear) |=> (bit_cnt == '0 && phase == PH_BYTE));
endmodule

// File: rtl/i2c_frame_guard.sv
module i2c_frame_guard
  import ifg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       xfer_sda_low,
  input  logic       xfer_scl_low,
  input  logic       sto_set,
  input  logic       si_clr,
  output logic       sda_pull,
  output logic       scl_pull,
  output logic       si,
  output logic       sto,
  output logic [7:0] status,
  output logic       unaddressed
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic start, stop, scl_rise, scl_fall;
  logic illegal, legal_start, legal_stop;
  logic si_q, sto_q, naddr_q, recover;

  assign raw_lines = {scl_in, sda_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    ifg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_lines[i]), .q(sync_lines[i])
    );
  end

  ifg_cond_detect u_det (
    .clk(clk), .rst_n(rst_n),
    .sda(sync_lines[0]), .scl(sync_lines[1]),
    .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  ifg_frame_track #(.BYTE_BITS(BYTE_BITS)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .freeze(si_q), .clear(recover),
    .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .illegal(illegal), .legal_start(legal_start), .legal_stop(legal_stop)
  );

  assign recover = si_q & sto_q & si_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q    <= 1'b0;
      sto_q   <= 1'b0;
      naddr_q <= 1'b1;
    end else if (recover) begin
      si_q    <= 1'b0;
      sto_q   <= 1'b0;
      naddr_q <= 1'b1;
    end else begin
      if (illegal) si_q <= 1'b1;
      if (si_q && sto_set) sto_q <= 1'b1;
      if (legal_start)     naddr_q <= 1'b0;
      else if (legal_stop) naddr_q <= 1'b1;
    end
  end

  assign si          = si_q;
  assign sto         = sto_q;
  assign unaddressed = naddr_q;
  assign status      = si_q ? ST_BUS_ERR : ST_NO_INFO;
  assign sda_pull    = xfer_sda_low & ~si_q;
  assign scl_pull    = xfer_scl_low & ~si_q;

  // R4: an out-of-place condition raises the interrupt flag
  assert_err_raises_si_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> si);

  // R8: the flag holds until the full handshake
  assert_si_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (si && !(sto && si_clr)) |=> si);

  // R9: stop request exists only alongside a pending error
  assert_sto_only_in_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !si |-> !sto);

  // R6: handshake returns to the not-addressed state with both bits low
  assert_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (si && sto && si_clr) |=> (!si && !sto && unaddressed));
endmodule

// File: tb/sim_i2c_frame_guard.sv
`timescale 1ns/1ps
module sim_i2c_frame_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_in = 1'b1, scl_in = 1'b1;
  logic xfer_sda_low = 1'b0, xfer_scl_low = 1'b0;
  logic sto_set = 1'b0, si_clr = 1'b0;
  logic sda_pull, scl_pull, si, sto, unaddressed;
  logic [7:0] status;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_frame_guard u0 (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .xfer_sda_low(xfer_sda_low), .xfer_scl_low(xfer_scl_low),
    .sto_set(sto_set), .si_clr(si_clr),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .si(si), .sto(sto),
    .status(status), .unaddressed(unaddressed)
  );

  // entry: [5:4] op (0 bus, 1 sto strobe, 2 si_clr strobe), [3] sda, [2] scl,
  // [1] expected si, [0] expected sto
  localparam logic [5:0] VEC [0:16] = '{
    6'b001100, 6'b000100, 6'b000000, 6'b001000, 6'b001100, 6'b001000,
    6'b000000, 6'b000100, 6'b000000, 6'b001000, 6'b001100,
    6'b000110,  // START after three address bits: R3
    6'b001110,  // STOP while frozen is ignored: R8
    6'b100010,  // si_clr with sto low is ignored: R8
    6'b010011,  // sto strobe during error: R6
    6'b100000,  // si_clr completes recovery: R6
    6'b001100
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic c);
    sda_in = d;
    scl_in = c;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe(input logic which_sto);
    if (which_sto) sto_set = 1'b1; else si_clr = 1'b1;
    @(negedge clk);
    sto_set = 1'b0;
    si_clr  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clocks(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 8'hF8);
    chk("R1 reset si", {7'd0, si}, 8'd0);
    chk("R1 reset sto", {7'd0, sto}, 8'd0);
    chk("R1 reset unaddressed", {7'd0, unaddressed}, 8'd1);

    for (int i = 0; i < 17; i++) begin
      case (VEC[i][5:4])
        2'd1: strobe(1'b1);
        2'd2: strobe(1'b0);
        default: step(VEC[i][3], VEC[i][2]);
      endcase
      chk($sformatf("R3/R8 vec%0d si", i), {7'd0, si}, {7'd0, VEC[i][1]});
      chk($sformatf("R6 vec%0d sto", i), {7'd0, sto}, {7'd0, VEC[i][0]});
      chk($sformatf("R1/R2 vec%0d status", i), status, VEC[i][1] ? 8'h00 : 8'hF8);
    end
    chk("R6 unaddressed after recovery", {7'd0, unaddressed}, 8'd1);

    // R9: stop strobe with no error
    strobe(1'b1);
    chk("R9 sto ignored", {7'd0, sto}, 8'd0);

    // R7: pass-through outside error
    xfer_sda_low = 1'b1;
    xfer_scl_low = 1'b1;
    @(negedge clk);
    chk("R7 sda follows", {7'd0, sda_pull}, 8'd1);
    chk("R7 scl follows", {7'd0, scl_pull}, 8'd1);

    // R5/R10: legal frame with repeated START and final STOP at boundaries
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R5 legal start unaddressed", {7'd0, unaddressed}, 8'd0);
    step(1'b0, 1'b0);
    clocks(9);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R5 repeated start si", {7'd0, si}, 8'd0);
    step(1'b0, 1'b0);
    clocks(9);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R10 boundary stop si", {7'd0, si}, 8'd0);
    chk("R5 stop unaddressed", {7'd0, unaddressed}, 8'd1);

    // R3: STOP during the acknowledge clock
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    clocks(8);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R3 stop in ack si", {7'd0, si}, 8'd1);
    chk("R2 status in error", status, 8'h00);
    chk("R7 sda released", {7'd0, sda_pull}, 8'd0);
    chk("R7 scl released", {7'd0, scl_pull}, 8'd0);
    step(1'b0, 1'b1);
    chk("R8 start ignored si", {7'd0, si}, 8'd1);
    chk("R8 start ignored unaddressed", {7'd0, unaddressed}, 8'd0);
    strobe(1'b1);
    chk("R6 sto set", {7'd0, sto}, 8'd1);
    chk("R7 still released", {7'd0, sda_pull}, 8'd0);
    strobe(1'b0);
    chk("R6 si cleared", {7'd0, si}, 8'd0);
    chk("R6 sto auto cleared", {7'd0, sto}, 8'd0);
    chk("R6 unaddressed", {7'd0, unaddressed}, 8'd1);
    chk("R1 status after recovery", status, 8'hF8);
    chk("R7 pulls restored", {6'd0, sda_pull, scl_pull}, 8'd3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule